// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the memory-side back end of a frame receiver. It takes a byte stream in which the final byte of each frame is flagged and carries six error flags. It stores the bytes into memory buffers that software hands over through a circular list of descriptors. Each descriptor is four 16-bit halfwords: a control/status word, a length, and the high and low halves of the buffer's byte address. The engine fills a buffer up to a programmed size and then moves on to the next descriptor. It marks where each frame starts and ends, writes back the byte count and the error status, and hands the descriptor back to software, optionally with an interrupt pulse.

Software owns a descriptor while its empty bit is 0. It sets the bit to give the descriptor to the engine. The engine clears the bit once it has filled and closed the buffer, unless the descriptor asks for continuous use. If the engine needs a buffer and finds a descriptor it does not own, it discards the rest of the current frame and pulses a busy event. The following frame then starts afresh in the same descriptor.

The controller is one state machine:
- Idle waits for a byte.
- GetStat, GetPtrHi and GetPtrLo read the descriptor.
- Decide goes to Fill if the engine owns the buffer, and otherwise to Discard with a busy pulse.
- Fill accepts bytes. It goes to PutLen when a byte ends the frame or fills the buffer.
- Discard accepts bytes until the end of the frame, then returns to Idle.
- PutLen writes the length and goes to PutStat.
- PutStat writes the status word, advances the ring and returns to Idle.

Top module: `rxbd_rx_engine`

## Requirements
- R1: Descriptor n sits at byte address `ring_base + 8n`, with status at +0, length at +2, pointer high at +4 and pointer low at +6. Frame byte k of a buffer goes to byte address `ptr + k`. An even byte address uses the upper lane (`mem_be=2'b10`, data in bits 15:8) and an odd one the lower lane (`mem_be=2'b01`). Descriptor halfwords are written with `mem_be=2'b11`.
- R2: Bytes are written only into a descriptor whose status bit 15 (empty) was 1 when fetched. On close, bit 15 is written as 0 unless continuous mode is set (see R10).
- R3: A buffer takes at most `max_len` bytes. A frame that still has bytes left when its buffer fills closes that buffer without the last mark and with length `max_len`. It continues in the next descriptor.
- R4: Status bit 10 (first) is set only in the descriptor where a frame begins. Bit 11 (last) is set only in the descriptor holding the frame's final byte. A new frame always begins in a fresh descriptor. Bits 13, 12 and 9 are written back unchanged; all other bits are zero.
- R5: The length halfword of a descriptor with the last mark holds the total byte count of the frame.
- R6: After closing a descriptor with status bit 13 (wrap) set, the next descriptor fetched is descriptor 0. Otherwise the next one is n+1.
- R7: `irq` pulses for exactly one cycle, during the status write, when the closed descriptor has status bit 12 set. It stays low at all other times.
- R8: The `in_err` value presented with the final byte is written to status bits 5:0 of the last descriptor: bit 5 overlength, bit 4 non-octet, bit 3 short, bit 2 CRC, bit 1 overrun, bit 0 collision. Descriptors without the last mark carry zeros there.
- R9: A fetched descriptor whose empty bit is 0 gives a one-cycle `busy_evt` pulse. The rest of the frame is accepted and discarded with no memory write, and the ring does not advance. The next frame starts in that same descriptor with the first mark set.
- R10: A descriptor with status bit 9 (continuous) set is closed with bit 15 still 1.
- R11: During reset `in_ready`, `irq`, `busy_evt`, `mem_we` and `mem_re` are low. After reset the first fetch is descriptor 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | AW | Byte address of descriptor 0 |
| max_len | input | LEN_W | Buffer size in bytes (at least 1) |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Engine accepts the byte this cycle |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Byte ends the frame |
| in_err | input | 6 | Receive error flags, sampled with in_last |
| mem_re | output | 1 | Halfword read request; data returns next cycle |
| mem_we | output | 1 | Write request |
| mem_addr | output | AW | Byte address |
| mem_be | output | 2 | Lane enables, bit 1 = even byte |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, one cycle after mem_re |
| irq | output | 1 | Descriptor-closed interrupt pulse |
| busy_evt | output | 1 | No-buffer pulse |

## Verification
A corrupted ring index or buffer counter shows up at the ports within a single write. The very next memory write lands at the wrong address, or writes a length that disagrees with the byte count. For this reason every write is compared, in order, against a reference model, in the cycle it is issued. A stale first/last flag or a lost error value appears in the status write that closes the descriptor. A wrong ownership decision appears as a missing or extra `busy_evt` pulse, followed by writes into a descriptor the model expects to stay untouched. The final memory image of every buffer byte and every status word is then checked again.

// File: rtl/rxbd_pkg.sv
`timescale 1ns/1ps
package rxbd_pkg;
    localparam int BIT_EMPTY = 15;
    localparam int BIT_WRAP  = 13;
    localparam int BIT_INTR  = 12;
    localparam int BIT_LAST  = 11;
    localparam int BIT_FIRST = 10;
    localparam int BIT_CONT  = 9;
    localparam int ERR_W     = 6;
    localparam logic [15:0] KEEP_MASK = 16'h3200;

    typedef enum logic [3:0] {
        ST_IDLE, ST_GET_STAT, ST_GET_PHI, ST_GET_PLO, ST_DECIDE,
        ST_FILL, ST_DISCARD, ST_PUT_LEN, ST_PUT_STAT
    } rx_state_e;
endpackage

// File: rtl/rxbd_ring_ptr.sv
`timescale 1ns/1ps
module rxbd_ring_ptr #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             wrap,
    output logic [IDX_W-1:0] idx
);
    always_ff @(posedge clk) begin
        if (!rst_n)       idx <= '0;
        else if (advance) idx <= wrap ? '0 : idx + IDX_W'(1);
    end

    // R6
    ring_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(idx));
endmodule

// File: rtl/rxbd_fill_cnt.sv
`timescale 1ns/1ps
module rxbd_fill_cnt #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             buf_clr,
    input  logic             step,
    input  logic             new_frame,
    output logic [LEN_W-1:0] buf_cnt,
    output logic [LEN_W-1:0] frame_cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_cnt   <= '0;
            frame_cnt <= '0;
        end else begin
            if (buf_clr)   buf_cnt <= '0;
            else if (step) buf_cnt <= buf_cnt + LEN_W'(1);
            if (step)      frame_cnt <= new_frame ? LEN_W'(1) : frame_cnt + LEN_W'(1);
        end
    end

    // R5
    frame_covers_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> frame_cnt >= buf_cnt);
endmodule

// File: rtl/rxbd_fsm.sv
`timescale 1ns/1ps
module rxbd_fsm
    import rxbd_pkg::*;
#(
    parameter int AW    = 32,
    parameter int IDX_W = 6,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    ring_base,
    input  logic [LEN_W-1:0] max_len,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    input  logic [ERR_W-1:0] in_err,
    output logic             mem_re,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [1:0]       mem_be,
    output logic [15:0]      mem_wdata,
    input  logic [15:0]      mem_rdata,
    output logic             irq,
    output logic             busy_evt,
    input  logic [IDX_W-1:0] idx,
    input  logic [LEN_W-1:0] buf_cnt,
    input  logic [LEN_W-1:0] frame_cnt,
    output logic             advance,
    output logic             wrap,
    output logic             buf_clr,
    output logic             step,
    output logic             new_frame
);
    rx_state_e state_q, state_d;
    logic [15:0]      st_q;
    logic [31:0]      ptr_q;
    logic             at_start_q, first_q, last_q;
    logic [ERR_W-1:0] err_q;
    logic [AW-1:0]    desc_addr, buf_addr;
    logic             accept, buf_full;
    logic [15:0]      close_word;

    assign desc_addr = ring_base + AW'({idx, 3'b000});
    assign buf_addr  = AW'(ptr_q) + AW'(buf_cnt);
    assign accept    = in_valid && in_ready;
    assign buf_full  = (buf_cnt == max_len - LEN_W'(1));

    always_comb begin
        close_word              = st_q & KEEP_MASK;
        close_word[BIT_EMPTY]   = st_q[BIT_CONT];
        close_word[BIT_FIRST]   = first_q;
        close_word[BIT_LAST]    = last_q;
        close_word[ERR_W-1:0]   = err_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        in_ready  = 1'b0;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_be    = 2'b00;
        mem_wdata = '0;
        irq       = 1'b0;
        busy_evt  = 1'b0;
        advance   = 1'b0;
        wrap      = 1'b0;
        buf_clr   = 1'b0;
        step      = 1'b0;
        new_frame = 1'b0;
        unique case (state_q)
            ST_IDLE: if (in_valid) state_d = ST_GET_STAT;
            ST_GET_STAT: begin
                mem_re   = 1'b1;
                mem_addr = desc_addr;
                state_d  = ST_GET_PHI;
            end
            ST_GET_PHI: begin
                mem_re   = 1'b1;
                mem_addr = desc_addr + AW'(4);
                state_d  = ST_GET_PLO;
            end
            ST_GET_PLO: begin
                mem_re   = 1'b1;
                mem_addr = desc_addr + AW'(6);
                state_d  = ST_DECIDE;
            end
            ST_DECIDE: begin
                if (st_q[BIT_EMPTY]) begin
                    buf_clr = 1'b1;
                    state_d = ST_FILL;
                end else begin
                    busy_evt = 1'b1;
                    state_d  = ST_DISCARD;
                end
            end
            ST_FILL: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    mem_we    = 1'b1;
                    mem_addr  = buf_addr;
                    mem_be    = buf_addr[0] ? 2'b01 : 2'b10;
                    mem_wdata = {in_data, in_data};
                    step      = 1'b1;
                    new_frame = at_start_q;
                    if (in_last || buf_full) state_d = ST_PUT_LEN;
                end
            end
            ST_DISCARD: begin
                in_ready = 1'b1;
                if (in_valid && in_last) state_d = ST_IDLE;
            end
            ST_PUT_LEN: begin
                mem_we    = 1'b1;
                mem_be    = 2'b11;
                mem_addr  = desc_addr + AW'(2);
                mem_wdata = last_q ? 16'(frame_cnt) : 16'(buf_cnt);
                state_d   = ST_PUT_STAT;
            end
            ST_PUT_STAT: begin
                mem_we    = 1'b1;
                mem_be    = 2'b11;
                mem_addr  = desc_addr;
                mem_wdata = close_word;
                irq       = st_q[BIT_INTR];
                advance   = 1'b1;
                wrap      = st_q[BIT_WRAP];
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            ptr_q      <= '0;
            at_start_q <= 1'b1;
            first_q    <= 1'b0;
            last_q     <= 1'b0;
            err_q      <= '0;
        end else begin
            if (state_q == ST_GET_PHI) st_q <= mem_rdata;
            if (state_q == ST_GET_PLO) ptr_q[31:16] <= mem_rdata;
            if (state_q == ST_DECIDE) begin
                ptr_q[15:0] <= mem_rdata;
                first_q     <= at_start_q;
            end
            if (state_q == ST_FILL && accept) begin
                at_start_q <= in_last;
                last_q     <= in_last;
                err_q      <= in_last ? in_err : '0;
            end
            if (state_q == ST_DISCARD && accept && in_last) at_start_q <= 1'b1;
        end
    end

    // R9
    discard_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_evt |=> in_ready && !mem_we);
    // R7
    irq_on_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> mem_we && mem_be == 2'b11 && !in_ready);
    // R3
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL) |-> buf_cnt < max_len);
    // R2
    owned_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> st_q[BIT_EMPTY]);
endmodule

// File: rtl/rxbd_rx_engine.sv
`timescale 1ns/1ps
module rxbd_rx_engine #(
    parameter int AW    = 32,
    parameter int IDX_W = 6,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    ring_base,
    input  logic [LEN_W-1:0] max_len,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    input  logic [5:0]       in_err,
    output logic             mem_re,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [1:0]       mem_be,
    output logic [15:0]      mem_wdata,
    input  logic [15:0]      mem_rdata,
    output logic             irq,
    output logic             busy_evt
);
    logic [IDX_W-1:0] idx;
    logic [LEN_W-1:0] buf_cnt, frame_cnt;
    logic advance, wrap, buf_clr, step, new_frame;

    rxbd_ring_ptr #(.IDX_W(IDX_W)) ring_i (
        .clk(clk), .rst_n(rst_n), .advance(advance), .wrap(wrap), .idx(idx)
    );

    rxbd_fill_cnt #(.LEN_W(LEN_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .buf_clr(buf_clr), .step(step),
        .new_frame(new_frame), .buf_cnt(buf_cnt), .frame_cnt(frame_cnt)
    );

    rxbd_fsm #(.AW(AW), .IDX_W(IDX_W), .LEN_W(LEN_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .max_len(max_len),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_last(in_last), .in_err(in_err),
        .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq), .busy_evt(busy_evt),
        .idx(idx), .buf_cnt(buf_cnt), .frame_cnt(frame_cnt),
        .advance(advance), .wrap(wrap), .buf_clr(buf_clr), .step(step),
        .new_frame(new_frame)
    );
endmodule

// File: tb/rxbd_rx_engine_tb_top.sv
`timescale 1ns/1ps
module rxbd_rx_engine_tb_top;
    localparam int NDESC = 32;
    localparam int BASE  = 32'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ring_base = BASE;
    logic [15:0] max_len = 16'd64;
    logic        in_valid = 1'b0, in_last = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic [5:0]  in_err = 6'h00;
    logic        in_ready, mem_re, mem_we, irq, busy_evt;
    logic [31:0] mem_addr;
    logic [1:0]  mem_be;
    logic [15:0] mem_wdata, mem_rdata;

    logic        sw_we = 1'b0;
    logic [31:0] sw_a = '0;
    logic [15:0] sw_d = '0;
    logic [15:0] mem [0:4095];

    int checks = 0, failures = 0;
    int exp_busy = 0, seen_busy = 0;
    int m_idx = 0, m_max = 64, fid = 0;
    bit m_empty [NDESC];
    logic [15:0] m_stat [NDESC];
    logic [7:0]  img [int];
    int          q_addr [$];
    logic [1:0]  q_be [$];
    logic [15:0] q_data [$];
    bit          q_irq [$];
    string       q_tag [$];

    always #5 clk = ~clk;

    rxbd_rx_engine dut_i (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .max_len(max_len),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_last(in_last), .in_err(in_err), .mem_re(mem_re), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .irq(irq), .busy_evt(busy_evt)
    );

    always @(posedge clk) begin
        if (sw_we) mem[sw_a[12:1]] <= sw_d;
        else if (mem_we) begin
            if (mem_be[1]) mem[mem_addr[12:1]][15:8] <= mem_wdata[15:8];
            if (mem_be[0]) mem[mem_addr[12:1]][7:0]  <= mem_wdata[7:0];
        end
        if (mem_re) mem_rdata <= mem[mem_addr[12:1]];
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int desc(input int d); return BASE + 8 * d; endfunction
    function automatic int bptr(input int d); return 32'h400 + 128 * d; endfunction
    function automatic bit c_wrap(input int d); return d == NDESC - 1; endfunction
    function automatic bit c_intr(input int d); return (d % 3) == 0; endfunction
    function automatic bit c_cont(input int d); return d == 5; endfunction
    function automatic logic [15:0] keep(input int d);
        return (c_wrap(d) ? 16'h2000 : 16'h0) | (c_intr(d) ? 16'h1000 : 16'h0) |
               (c_cont(d) ? 16'h0200 : 16'h0);
    endfunction

    // per-cycle comparison of every memory write against the model
    always begin
        @(negedge clk);
        #3;
        if (rst_n) begin
            if (busy_evt) seen_busy++;
            if (mem_we) begin
                if (q_addr.size() == 0) begin
                    check(1'b0, "R1", "unexpected write addr", mem_addr, 0);
                end else begin
                    automatic int         ea = q_addr.pop_front();
                    automatic logic [1:0] eb = q_be.pop_front();
                    automatic logic [15:0] ed = q_data.pop_front();
                    automatic bit         ei = q_irq.pop_front();
                    automatic string      et = q_tag.pop_front();
                    automatic logic [15:0] mk = {{8{eb[1]}}, {8{eb[0]}}};
                    check(mem_addr == ea && mem_be == eb, et, "write address/lanes",
                          {mem_addr, 2'b00, mem_be}, {ea, 2'b00, eb});
                    check((mem_wdata & mk) == (ed & mk), et, "write data",
                          mem_wdata & mk, ed & mk);
                    if (eb == 2'b11 && addr_is_stat(ea))
                        check(irq == ei, "R7", "irq at close", irq, ei);
                end
            end else if (irq) begin
                check(1'b0, "R7", "irq without close", 1, 0);
            end
        end
    end

    function automatic bit addr_is_stat(input int a);
        return a >= BASE && a < BASE + 8 * NDESC && ((a - BASE) % 8) == 0;
    endfunction

    task automatic sw_write(input int a, input logic [15:0] d);
        @(negedge clk);
        sw_we = 1'b1; sw_a = a; sw_d = d;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic rearm(input bit own);
        for (int d = 0; d < NDESC; d++) begin
            m_stat[d]  = keep(d) | (own ? 16'h8000 : 16'h0);
            m_empty[d] = own;
            sw_write(desc(d), m_stat[d]);
        end
    endtask

    task automatic push(input int a, input logic [1:0] b, input logic [15:0] d,
                        input bit i, input string t);
        q_addr.push_back(a); q_be.push_back(b); q_data.push_back(d);
        q_irq.push_back(i); q_tag.push_back(t);
    endtask

    function automatic logic [7:0] bval(input int f, input int i);
        return 8'((f * 29 + i * 7 + (i >> 8)) & 255);
    endfunction

    task automatic send_byte(input logic [7:0] d, input logic lst, input logic [5:0] e);
        automatic bit done = 1'b0;
        in_valid = 1'b1; in_data = d; in_last = lst; in_err = e;
        while (!done) begin
            #2;
            done = in_ready;
            @(negedge clk);
        end
        in_valid = 1'b0; in_last = 1'b0; in_err = 6'h00;
    endtask

    task automatic send_frame(input int n, input logic [5:0] e);
        automatic int i = 0;
        automatic bit first = 1'b1;
        fid++;
        while (i < n) begin
            automatic int d = m_idx;
            automatic int take;
            automatic bit lastf;
            automatic logic [15:0] sw;
            automatic string tg;
            if (!m_empty[d]) begin exp_busy++; break; end
            take  = (n - i < m_max) ? n - i : m_max;
            lastf = (i + take == n);
            for (int k = 0; k < take; k++) begin
                automatic int a = bptr(d) + k;
                automatic logic [7:0] b = bval(fid, i + k);
                push(a, a[0] ? 2'b01 : 2'b10, {b, b}, 1'b0, "R1");
                img[a] = b;
            end
            push(desc(d) + 2, 2'b11, 16'(lastf ? n : take), 1'b0, lastf ? "R5" : "R3");
            sw = keep(d) | (c_cont(d) ? 16'h8000 : 16'h0) | (first ? 16'h0400 : 16'h0) |
                 (lastf ? 16'h0800 : 16'h0) | (lastf ? {10'h0, e} : 16'h0);
            tg = c_wrap(d) ? "R6" : c_cont(d) ? "R10" : (lastf && e != 0) ? "R8" : "R4";
            push(desc(d), 2'b11, sw, c_intr(d), tg);
            m_stat[d]  = sw;
            m_empty[d] = c_cont(d);
            m_idx = c_wrap(d) ? 0 : d + 1;
            first = 1'b0;
            i += take;
        end
        for (int j = 0; j < n; j++) begin
            send_byte(bval(fid, j), j == n - 1, (j == n - 1) ? e : 6'h00);
            if (j % 7 == 3) @(negedge clk);
        end
    endtask

    task automatic drain;
        while (q_addr.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int d = 0; d < NDESC; d++) begin
            sw_write(desc(d) + 2, 16'h0);
            sw_write(desc(d) + 4, 16'(bptr(d) >> 16));
            sw_write(desc(d) + 6, 16'(bptr(d)));
        end
        rearm(1'b1);
        @(negedge clk); #3;
        // R11 reset state
        check(!in_ready && !irq && !busy_evt && !mem_we && !mem_re, "R11", "outputs in reset",
              {in_ready, irq, busy_evt, mem_we, mem_re}, 0);
        rst_n = 1'b1;
        @(negedge clk); #3;
        check(!in_ready && !mem_we && !mem_re, "R11", "idle after reset",
              {in_ready, mem_we, mem_re}, 0);
        @(negedge clk);

        send_frame(64, 6'h00);    // exact fill, one buffer
        send_frame(65, 6'h00);    // one byte spills
        send_frame(1518, 6'h00);  // long frame, passes continuous descriptor 5
        send_frame(200, 6'h24);   // errors on last buffer only (R8)
        send_frame(100, 6'h00);   // wraps to descriptor 0 which is not owned (R9)
        drain();
        rearm(1'b1);
        send_frame(70, 6'h03);
        drain();
        max_len = 16'd16; m_max = 16;
        send_frame(40, 6'h10);
        send_frame(10, 6'h00);
        drain();
        rearm(1'b0);
        send_frame(20, 6'h00);    // no buffer at frame start (R9)
        drain();
        rearm(1'b1);
        send_frame(16, 6'h08);    // restarts in same descriptor with first mark
        drain();

        check(q_addr.size() == 0, "R4", "pending expected writes", q_addr.size(), 0);
        check(seen_busy == exp_busy, "R9", "busy pulses", seen_busy, exp_busy);
        foreach (img[a]) begin
            automatic logic [15:0] h = mem[a[12:1]];
            automatic logic [7:0] got = a[0] ? h[7:0] : h[15:8];
            check(got == img[a], "R1", $sformatf("buffer byte @%0h", a), got, img[a]);
        end
        for (int d = 0; d < NDESC; d++)
            check(mem[desc(d) >> 1] == m_stat[d], "R2", $sformatf("status of desc %0d", d),
                  mem[desc(d) >> 1], m_stat[d]);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule